// File: doc/BRIEF.md
# Ethernet Destination Address Filter

This block decides, from the destination field at the head of a received frame, whether the frame is taken in. The first six frame bytes arrive one per `byte_valid` cycle. A `frame_start` pulse marks the first of them. While they arrive, the block builds the 48-bit destination and runs a CRC-32 over it. One clock after the sixth byte it produces a one-cycle strobe and an accept flag. Both stay valid until the next frame begins.

A frame is accepted on any of four paths:
- the destination equals the programmed station address;
- the destination is the all-ones broadcast;
- the destination is a group address, and the CRC selects a set bit in a 64-bit hash filter;
- promiscuous mode is on.

A frame is only accepted while reception is enabled. Software fills the station-address and hash-filter tables byte by byte. It can do so only while an update-open control is set. While that control is set, reception is forced off.

Top module: `dst_addr_filter`

## Requirements
- R1: After reset, `dec_valid`, `dec_accept` and `dec_strobe` are 0. Every byte of both tables reads back as 0.
- R2: Destination bytes are taken in arrival order: the first byte received is byte 0. If the sixth byte is presented in cycle t, then `dec_strobe` and `dec_valid` are 1 in cycle t+1, and `dec_strobe` is 0 again in cycle t+2.
- R3: Once valid, `dec_valid` and `dec_accept` hold their values, and further bytes are ignored, until `frame_start`. The cycle after `frame_start`, `dec_valid` is 0. A byte presented together with `frame_start` counts as byte 0 of the new frame.
- R4: A destination whose byte i equals station-table byte i for all i in 0..5 is accepted. A destination that differs in any one byte is not accepted on this path.
- R5: The destination FF:FF:FF:FF:FF:FF is always accepted while reception is enabled, whatever the table contents.
- R6: When bit 0 of byte 0 is 1 (a group address), a CRC is computed over the 48 destination bits. The CRC uses polynomial 0x04C11DB7, starts from all ones, takes each byte least significant bit first, and has no final inversion. Its bits 31..26 form an index n, with bit 31 as the MSB. The frame is accepted when hash-table byte n/8, bit n%8, is 1, and rejected on this path when that bit is 0.
- R7: A destination with bit 0 of byte 0 equal to 0 never uses the hash path. With every filter bit set, a non-matching individual address is still rejected.
- R8: With `promisc_en` = 1, every frame is accepted while reception is enabled.
- R9: Table writes take effect only while `addr_chg` = 1. `tbl_rdata` is 0 while `addr_chg` = 0. `rx_active` equals `rx_enable_req` AND NOT `addr_chg`. `tbl_sel` = 0 selects the station table (indices 0..5), and `tbl_sel` = 1 selects the hash table (indices 0..7).
- R10: A frame whose sixth byte arrives while `rx_active` = 0 is rejected (`dec_accept` = 0), even if it is a broadcast or promiscuous mode is on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Start of a new frame; clears the previous decision |
| byte_valid | input | 1 | `byte_data` holds a frame byte |
| byte_data | input | 8 | Frame byte |
| promisc_en | input | 1 | Accept all frames |
| rx_enable_req | input | 1 | Software receive enable |
| addr_chg | input | 1 | Opens the tables for update and forces reception off |
| tbl_wr_en | input | 1 | Write `tbl_wdata` to the selected table byte |
| tbl_sel | input | 1 | 0 = station table, 1 = hash table |
| tbl_idx | input | 3 | Table byte index |
| tbl_wdata | input | 8 | Table write data |
| tbl_rdata | output | 8 | Table read data for `tbl_sel`/`tbl_idx` |
| rx_active | output | 1 | Effective receive enable |
| dec_strobe | output | 1 | One-cycle pulse when a decision is made |
| dec_valid | output | 1 | Decision is valid |
| dec_accept | output | 1 | Frame accepted |

## Verification
The assertions assume that `frame_start` is a single-cycle pulse. They also assume that `addr_chg`, `rx_enable_req` and `promisc_en` are steady in the cycle that carries the sixth byte. The hold property further relies on no new frame starting while its decision is checked. The directed tasks change configuration only between frames, and always raise `frame_start` together with the first byte. The hash-path cases do not rely on any hard-coded hash result. The bench computes the filter index with its own reflected CRC loop and programs that bit, or every bit except it.

// File: rtl/daf_pkg.sv
package daf_pkg;
  localparam int BYTE_W     = 8;
  localparam int ADDR_BYTES = 6;
  localparam int ADDR_W     = ADDR_BYTES * BYTE_W;
  localparam int FILT_BYTES = 8;
  localparam int FILT_BITS  = FILT_BYTES * BYTE_W;
  localparam int HASH_W     = $clog2(FILT_BITS);
  localparam int CRC_W      = 32;
  localparam int IDX_W      = 3;
  localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C11DB7;
  localparam logic [CRC_W-1:0] CRC_SEED = '1;

  typedef enum logic {TBL_STATION = 1'b0, TBL_HASH = 1'b1} tbl_sel_e;

  typedef struct packed {
    logic promisc;
    logic bcast;
    logic station;
    logic hash;
  } hit_t;

  // Advance the CRC over one byte, least significant bit first.
  function automatic logic [CRC_W-1:0] crc_step_byte(input logic [CRC_W-1:0] c,
                                                     input logic [BYTE_W-1:0] d);
    logic [CRC_W-1:0] r;
    logic fb;
    r = c;
    for (int b = 0; b < BYTE_W; b++) begin
      fb = r[CRC_W-1] ^ d[b];
      r  = {r[CRC_W-2:0], 1'b0};
      if (fb) r = r ^ CRC_POLY;
    end
    return r;
  endfunction

  // Top bits of the CRC select one bit of the hash filter.
  function automatic logic [HASH_W-1:0] hash_index(input logic [CRC_W-1:0] c);
    return c[CRC_W-1 -: HASH_W];
  endfunction
endpackage

// File: rtl/daf_addr_tables.sv
module daf_addr_tables
  import daf_pkg::*;
#(
  parameter int N_STATION = ADDR_BYTES,
  parameter int N_HASH    = FILT_BYTES,
  parameter int W         = BYTE_W,
  parameter int IW        = IDX_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  upd_open,
  input  logic                  wr_en,
  input  tbl_sel_e              sel,
  input  logic [IW-1:0]         idx,
  input  logic [W-1:0]          wdata,
  output logic [W-1:0]          rdata,
  output logic [N_STATION*W-1:0] station_addr,
  output logic [N_HASH*W-1:0]   hash_bits,
  output logic                  wr_taken
);
  logic [N_STATION*W-1:0] station_q;
  logic [N_HASH*W-1:0]    hash_q;
  logic [W-1:0]           station_rd;
  logic [W-1:0]           hash_rd;

  assign wr_taken = wr_en && upd_open;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      station_q <= '0;
      hash_q    <= '0;
    end else if (wr_taken) begin
      for (int i = 0; i < N_STATION; i++)
        if (sel == TBL_STATION && idx == IW'(i)) station_q[i*W +: W] <= wdata;
      for (int i = 0; i < N_HASH; i++)
        if (sel == TBL_HASH && idx == IW'(i)) hash_q[i*W +: W] <= wdata;
    end
  end

  always_comb begin
    station_rd = '0;
    hash_rd    = '0;
    for (int i = 0; i < N_STATION; i++)
      if (idx == IW'(i)) station_rd = station_q[i*W +: W];
    for (int i = 0; i < N_HASH; i++)
      if (idx == IW'(i)) hash_rd = hash_q[i*W +: W];
  end

  assign rdata        = !upd_open ? '0 : (sel == TBL_STATION ? station_rd : hash_rd);
  assign station_addr = station_q;
  assign hash_bits    = hash_q;
endmodule

// File: rtl/daf_byte_collect.sv
module daf_byte_collect
  import daf_pkg::*;
#(
  parameter int N_BYTES = ADDR_BYTES,
  parameter int W       = BYTE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_start,
  input  logic               byte_valid,
  input  logic [W-1:0]       byte_data,
  output logic               take,
  output logic               last,
  output logic [N_BYTES*W-1:0] dest_next
);
  localparam int CW = $clog2(N_BYTES + 1);

  logic [CW-1:0]        cnt_q;
  logic [CW-1:0]        cnt_eff;
  logic [N_BYTES*W-1:0] dest_q;
  logic [N_BYTES*W-1:0] dest_base;

  assign cnt_eff   = frame_start ? '0 : cnt_q;
  assign dest_base = frame_start ? '0 : dest_q;
  assign take      = byte_valid && (cnt_eff < CW'(N_BYTES));
  assign last      = take && (cnt_eff == CW'(N_BYTES - 1));

  for (genvar g = 0; g < N_BYTES; g++) begin : g_slot
    assign dest_next[g*W +: W] = (take && cnt_eff == CW'(g)) ? byte_data
                                                           : dest_base[g*W +: W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      dest_q <= '0;
    end else if (take) begin
      cnt_q  <= cnt_eff + CW'(1);
      dest_q <= dest_next;
    end else if (frame_start) begin
      cnt_q  <= '0;
      dest_q <= '0;
    end
  end
endmodule

// File: rtl/daf_crc_acc.sv
module daf_crc_acc
  import daf_pkg::*;
#(
  parameter int W  = BYTE_W,
  parameter int CW = CRC_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          step,
  input  logic [W-1:0]  data,
  output logic [CW-1:0] crc_next
);
  logic [CW-1:0] crc_q;
  logic [CW-1:0] crc_base;

  assign crc_base = restart ? CRC_SEED : crc_q;
  assign crc_next = step ? crc_step_byte(crc_base, data) : crc_base;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= CRC_SEED;
    else if (step || restart) crc_q <= crc_next;
  end
endmodule

// File: rtl/daf_match_logic.sv
module daf_match_logic
  import daf_pkg::*;
#(
  parameter int N_BYTES = ADDR_BYTES,
  parameter int W       = BYTE_W,
  parameter int FB      = FILT_BITS,
  parameter int CW      = CRC_W
) (
  input  logic [N_BYTES*W-1:0] dest,
  input  logic [CW-1:0]        crc,
  input  logic [N_BYTES*W-1:0] station,
  input  logic [FB-1:0]        filt,
  input  logic                 promisc,
  output hit_t                 hits
);
  logic [N_BYTES-1:0] byte_eq;
  logic [HASH_W-1:0]  hidx;
  logic               group_addr;

  for (genvar g = 0; g < N_BYTES; g++) begin : g_cmp
    assign byte_eq[g] = dest[g*W +: W] == station[g*W +: W];
  end

  assign group_addr   = dest[0];
  assign hidx         = hash_index(crc);
  assign hits.promisc = promisc;
  assign hits.bcast   = &dest;
  assign hits.station = &byte_eq;
  assign hits.hash    = group_addr && filt[hidx];
endmodule

// File: rtl/dst_addr_filter.sv
module dst_addr_filter
  import daf_pkg::*;
#(
  parameter int N_BYTES = ADDR_BYTES,
  parameter int N_HASH  = FILT_BYTES,
  parameter int W       = BYTE_W,
  parameter int IW      = IDX_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_start,
  input  logic          byte_valid,
  input  logic [W-1:0]  byte_data,
  input  logic          promisc_en,
  input  logic          rx_enable_req,
  input  logic          addr_chg,
  input  logic          tbl_wr_en,
  input  logic          tbl_sel,
  input  logic [IW-1:0] tbl_idx,
  input  logic [W-1:0]  tbl_wdata,
  output logic [W-1:0]  tbl_rdata,
  output logic          rx_active,
  output logic          dec_strobe,
  output logic          dec_valid,
  output logic          dec_accept
);
  localparam int AW = N_BYTES * W;
  localparam int FB = N_HASH * W;

  logic [AW-1:0]    station_addr;
  logic [FB-1:0]    hash_bits;
  logic             wr_taken;
  logic             byte_take;
  logic             last_byte;
  logic [AW-1:0]    dest_next;
  logic [CRC_W-1:0] crc_next;
  hit_t             hits;
  logic             any_hit;
  logic             bcast_hit;
  logic             strobe_q, valid_q, accept_q;

  assign rx_active = rx_enable_req && !addr_chg;

  daf_addr_tables #(.N_STATION(N_BYTES), .N_HASH(N_HASH), .W(W), .IW(IW)) tables_i (
    .clk(clk), .rst_n(rst_n), .upd_open(addr_chg), .wr_en(tbl_wr_en),
    .sel(tbl_sel_e'(tbl_sel)), .idx(tbl_idx), .wdata(tbl_wdata), .rdata(tbl_rdata),
    .station_addr(station_addr), .hash_bits(hash_bits), .wr_taken(wr_taken)
  );

  daf_byte_collect #(.N_BYTES(N_BYTES), .W(W)) collect_i (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .byte_valid(byte_valid),
    .byte_data(byte_data), .take(byte_take), .last(last_byte), .dest_next(dest_next)
  );

  daf_crc_acc #(.W(W), .CW(CRC_W)) crc_i (
    .clk(clk), .rst_n(rst_n), .restart(frame_start), .step(byte_take),
    .data(byte_data), .crc_next(crc_next)
  );

  daf_match_logic #(.N_BYTES(N_BYTES), .W(W), .FB(FB), .CW(CRC_W)) match_i (
    .dest(dest_next), .crc(crc_next), .station(station_addr), .filt(hash_bits),
    .promisc(promisc_en), .hits(hits)
  );

  assign any_hit   = |hits;
  assign bcast_hit = hits.bcast;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q <= 1'b0;
      valid_q  <= 1'b0;
      accept_q <= 1'b0;
    end else begin
      strobe_q <= last_byte;
      if (last_byte) begin
        valid_q  <= 1'b1;
        accept_q <= rx_active && any_hit;
      end else if (frame_start) begin
        valid_q  <= 1'b0;
        accept_q <= 1'b0;
      end
    end
  end

  assign dec_strobe = strobe_q;
  assign dec_valid  = valid_q;
  assign dec_accept = accept_q;
endmodule

// File: rtl/daf_checker.sv
module daf_checker #(
  parameter int AW = 48,
  parameter int FB = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          frame_start,
  input logic          addr_chg,
  input logic          rx_enable_req,
  input logic          promisc_en,
  input logic          last_byte,
  input logic          bcast_hit,
  input logic          dec_strobe,
  input logic          dec_valid,
  input logic          dec_accept,
  input logic [AW-1:0] station_addr,
  input logic [FB-1:0] hash_bits
);
  assert_decision_timing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    last_byte |=> dec_strobe && dec_valid);

  assert_single_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dec_strobe |=> !dec_strobe);

  assert_clear_on_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !dec_valid);

  assert_hold_decision_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid && !frame_start && !last_byte |=> dec_valid && $stable(dec_accept));

  assert_bcast_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    last_byte && bcast_hit && rx_enable_req && !addr_chg |=> dec_accept);

  assert_promisc_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    last_byte && promisc_en && rx_enable_req && !addr_chg |=> dec_accept);

  assert_tables_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_chg |=> $stable(station_addr) && $stable(hash_bits));

  assert_rx_off_reject_R10: assert property (@(posedge clk) disable iff (!rst_n)
    last_byte && !(rx_enable_req && !addr_chg) |=> !dec_accept);
endmodule

bind dst_addr_filter daf_checker #(.AW(AW), .FB(FB)) chk_i (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .addr_chg(addr_chg),
  .rx_enable_req(rx_enable_req), .promisc_en(promisc_en), .last_byte(last_byte),
  .bcast_hit(bcast_hit), .dec_strobe(dec_strobe), .dec_valid(dec_valid),
  .dec_accept(dec_accept), .station_addr(station_addr), .hash_bits(hash_bits)
);

// File: tb/dst_addr_filter_tb.sv
`timescale 1ns/1ps
module dst_addr_filter_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_start = 1'b0, byte_valid = 1'b0;
  logic [7:0] byte_data = '0;
  logic       promisc_en = 1'b0, rx_enable_req = 1'b0, addr_chg = 1'b0;
  logic       tbl_wr_en = 1'b0, tbl_sel = 1'b0;
  logic [2:0] tbl_idx = '0;
  logic [7:0] tbl_wdata = '0, tbl_rdata;
  logic       rx_active, dec_strobe, dec_valid, dec_accept;

  int n_checks = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dst_addr_filter dut_i (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .byte_valid(byte_valid),
    .byte_data(byte_data), .promisc_en(promisc_en), .rx_enable_req(rx_enable_req),
    .addr_chg(addr_chg), .tbl_wr_en(tbl_wr_en), .tbl_sel(tbl_sel), .tbl_idx(tbl_idx),
    .tbl_wdata(tbl_wdata), .tbl_rdata(tbl_rdata), .rx_active(rx_active),
    .dec_strobe(dec_strobe), .dec_valid(dec_valid), .dec_accept(dec_accept)
  );

  localparam logic [47:0] STATION = 48'h554433221102; // 02:11:22:33:44:55
  localparam logic [47:0] BCAST   = 48'hFFFFFFFFFFFF;
  localparam logic [47:0] MCAST   = 48'hFB00005E0001; // 01:00:5E:00:00:FB

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Reflected CRC over the 48 address bits; index bit 5 is CRC bit 31.
  function automatic logic [5:0] ref_hash(input logic [47:0] a);
    logic [31:0] r = 32'hFFFFFFFF;
    logic [5:0]  h;
    for (int k = 0; k < 48; k++)
      r = (r[0] ^ a[k]) ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    for (int j = 0; j < 6; j++) h[5-j] = r[j];
    return h;
  endfunction

  task automatic tbl_write(input bit sel, input int idx, input logic [7:0] d);
    @(negedge clk);
    tbl_wr_en = 1'b1; tbl_sel = sel; tbl_idx = 3'(idx); tbl_wdata = d;
    @(negedge clk);
    tbl_wr_en = 1'b0;
  endtask

  task automatic tbl_read_chk(input bit sel, input int idx, input logic [7:0] exp,
                              input string req);
    @(negedge clk);
    tbl_sel = sel; tbl_idx = 3'(idx);
    #1;
    chk(tbl_rdata == exp, req, tbl_rdata, exp);
  endtask

  task automatic load_filter(input logic [63:0] f);
    addr_chg = 1'b1;
    for (int i = 0; i < 8; i++) tbl_write(1'b1, i, f[i*8 +: 8]);
    @(negedge clk);
    addr_chg = 1'b0;
  endtask

  task automatic send_frame(input logic [47:0] a, input bit exp, input string req);
    @(negedge clk);
    frame_start = 1'b1; byte_valid = 1'b1; byte_data = a[7:0];
    for (int i = 1; i < 6; i++) begin
      @(negedge clk);
      frame_start = 1'b0; byte_data = a[i*8 +: 8];
    end
    @(negedge clk);
    byte_valid = 1'b0;
    chk(dec_strobe && dec_valid, "R2 strobe", {dec_strobe, dec_valid}, 2'b11);
    chk(dec_accept == exp, req, dec_accept, exp);
    @(negedge clk);
    chk(!dec_strobe && dec_valid, "R2 strobe width", {dec_strobe, dec_valid}, 2'b01);
  endtask

  task automatic t_reset();
    chk(!dec_valid && !dec_accept && !dec_strobe, "R1 outputs",
        {dec_valid, dec_accept, dec_strobe}, 0);
    addr_chg = 1'b1;
    for (int i = 0; i < 6; i++) tbl_read_chk(1'b0, i, 8'h00, "R1 station table");
    for (int i = 0; i < 8; i++) tbl_read_chk(1'b1, i, 8'h00, "R1 hash table");
    addr_chg = 1'b0;
  endtask

  task automatic t_program();
    addr_chg = 1'b1;
    for (int i = 0; i < 6; i++) tbl_write(1'b0, i, STATION[i*8 +: 8]);
    for (int i = 0; i < 6; i++) tbl_read_chk(1'b0, i, STATION[i*8 +: 8], "R9 readback");
    rx_enable_req = 1'b1;
    #1 chk(!rx_active, "R9 rx forced off", rx_active, 0);
    addr_chg = 1'b0;
    tbl_read_chk(1'b0, 1, 8'h00, "R9 read gated");
    tbl_write(1'b0, 0, 8'hEE);
    addr_chg = 1'b1;
    tbl_read_chk(1'b0, 0, 8'h02, "R9 locked write ignored");
    addr_chg = 1'b0;
    #1 chk(rx_active, "R9 rx active", rx_active, 1);
  endtask

  task automatic t_station();
    send_frame(STATION, 1'b1, "R4 exact match");
    send_frame(STATION ^ 48'h000100000000, 1'b0, "R4 one byte differs");
  endtask

  task automatic t_bcast();
    send_frame(BCAST, 1'b1, "R5 broadcast");
  endtask

  task automatic t_hash();
    logic [5:0] h = ref_hash(MCAST);
    logic [63:0] one = 64'd1 << h;
    load_filter(one);
    send_frame(MCAST, 1'b1, "R6 hash bit set");
    load_filter(~one);
    send_frame(MCAST, 1'b0, "R6 hash bit clear");
    load_filter('1);
    send_frame(48'h0000000000A2, 1'b0, "R7 individual not hashed");
    load_filter('0);
  endtask

  task automatic t_hold();
    send_frame(STATION, 1'b1, "R3 first decision");
    @(negedge clk);
    byte_valid = 1'b1; byte_data = 8'h77;
    repeat (3) @(negedge clk);
    byte_valid = 1'b0;
    chk(dec_valid && dec_accept && !dec_strobe, "R3 extra bytes ignored",
        {dec_valid, dec_accept, dec_strobe}, 3'b110);
    @(negedge clk);
    frame_start = 1'b1; byte_valid = 1'b1; byte_data = 8'h02;
    @(negedge clk);
    frame_start = 1'b0; byte_valid = 1'b0;
    chk(!dec_valid && !dec_accept, "R3 cleared on start", {dec_valid, dec_accept}, 0);
    for (int i = 1; i < 6; i++) begin
      byte_valid = 1'b1; byte_data = STATION[i*8 +: 8];
      @(negedge clk);
    end
    byte_valid = 1'b0;
    chk(dec_strobe && dec_accept, "R3 start byte is byte 0",
        {dec_strobe, dec_accept}, 2'b11);
  endtask

  task automatic t_promisc();
    promisc_en = 1'b1;
    send_frame(48'h0000CAFE0040, 1'b1, "R8 promiscuous");
    promisc_en = 1'b0;
    send_frame(48'h0000CAFE0040, 1'b0, "R8 promiscuous off");
  endtask

  task automatic t_rx_off();
    rx_enable_req = 1'b0;
    promisc_en = 1'b1;
    send_frame(BCAST, 1'b0, "R10 receive disabled");
    promisc_en = 1'b0;
    rx_enable_req = 1'b1; addr_chg = 1'b1;
    send_frame(BCAST, 1'b0, "R9 address change blocks reception");
    addr_chg = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_program();
    t_station();
    t_bcast();
    t_hash();
    t_hold();
    t_promisc();
    t_rx_off();
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule